// File: doc/BRIEF.md
# Four-Phase Bundled-Data Command Sequencer

This block is a clocked controller that performs one datapath action per accepted operation: a register assignment from a selected source, a register reload from the source already selected, or a single-bit test of the register. Every datapath action is wrapped in its own complete four-phase handshake: request up, acknowledge up, request down, acknowledge down. There are three handshake channels, one for each element: mux select, register load and comparator flip-flop.

The acknowledge of each channel is not produced by completion detection. A matched-delay element raises it a programmable number of clock cycles after its request rises, and drops it the same number of cycles after the request falls. The delay is sampled from `bund_dly` when an operation is accepted. Each datapath element acts on the rising edge of its own request. The mux latches the source index, the register captures the selected source, and the comparator flip-flop stores whether the tested bit equals the reference. For a test, the stored flag is reported as `branch_taken`: 1 means the IF branch is taken and 0 means the ELSE branch.

Operations enter through an `op_valid`/`op_ready` handshake. Completion is signalled by a one-cycle `op_done` pulse.

Top module: `hs_cmd_seq`

## Requirements
- R1: While `rst` is high and after it is released, every request and acknowledge is low, `op_ready` is 1, `op_done` is 0, `reg_q` is 0 and `branch_taken` is 0. A reset in the middle of an operation aborts it.
- R2: An operation is accepted only on a clock edge where `op_valid` and `op_ready` are both high. `op_ready` is low from acceptance until completion, and an `op_valid` raised in that window is ignored.
- R3: The acknowledge of a channel rises N cycles after its request rises and falls N cycles after its request falls. N is `bund_dly` sampled at acceptance, and the value 0 is treated as 1.
- R4: A request is held high until its acknowledge is high, and is then dropped. At most one request is high at any time. No request rises while any acknowledge is high.
- R5: `op_kind` 2'b00 (assign) runs the select handshake to completion before the load handshake begins. `op_done` rises 4N+4 cycles after the acceptance edge.
- R6: The mux latches `op_src` on the rising edge of the select request. The register captures source `op_src` (bits `[op_src*DATA_W +: DATA_W]` of `src_bus`) on the rising edge of the load request.
- R7: `op_kind` 2'b01 (reload) runs only the load handshake. It captures the source chosen by the last select and ignores `op_src`. `op_done` rises 2N+2 cycles after acceptance.
- R8: `op_kind` 2'b10 or 2'b11 (test) runs only the compare handshake. On the rising edge of the compare request, the flag becomes 1 if `reg_q[op_bit]` equals `op_ref` and 0 otherwise. `reg_q` is unchanged, and `op_done` rises 2N+2 cycles after acceptance.
- R9: `op_done` is high for exactly one cycle, one cycle after the final acknowledge falls, with all acknowledges low. `branch_taken` is then valid and holds until the next test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Sequencer idle, operation can be taken |
| op_kind | input | 2 | 00 assign, 01 reload, 1x bit test |
| op_src | input | SEL_W (2) | Source index for assign |
| op_bit | input | BIT_W (3) | Register bit tested |
| op_ref | input | 1 | Reference value for the test |
| bund_dly | input | DLY_W (4) | Bundling delay in cycles (0 acts as 1) |
| src_bus | input | NSRC*DATA_W (32) | Concatenated data sources |
| sel_req | output | 1 | Mux-select request |
| sel_ack | output | 1 | Mux-select acknowledge |
| load_req | output | 1 | Register-load request |
| load_ack | output | 1 | Register-load acknowledge |
| cmp_req | output | 1 | Compare request |
| cmp_ack | output | 1 | Compare acknowledge |
| reg_q | output | DATA_W (8) | Datapath register |
| branch_taken | output | 1 | Stored comparison flag |
| op_done | output | 1 | One-cycle completion pulse |

## Verification
Each handshake costs 2N+2 cycles: N cycles for the acknowledge to rise, one cycle for the request to drop, N cycles for the acknowledge to fall, and one cycle to observe it. An assign therefore completes at 4N+4 cycles and a reload or test at 2N+2. The bench counts clock edges from the acceptance edge to the first `op_done` seen at a falling edge and compares the count with that figure. It reads `reg_q` and `branch_taken` only after `op_done`. The acknowledge delay is measured separately, in falling-edge samples between the edge of a request and the edge of its acknowledge, and must equal N on both the rise and the fall.

// File: rtl/hs_cmd_seq_pkg.sv
package hs_cmd_seq_pkg;

  localparam int NCH    = 3;
  localparam int CH_SEL = 0;
  localparam int CH_LD  = 1;
  localparam int CH_CMP = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL_UP,
    ST_SEL_DN,
    ST_LD_UP,
    ST_LD_DN,
    ST_CMP_UP,
    ST_CMP_DN
  } seq_state_e;

  function automatic logic kind_is_test(input logic [1:0] k);
    return k[1];
  endfunction

  function automatic logic kind_is_reload(input logic [1:0] k);
    return (k == 2'b01);
  endfunction

endpackage

// File: rtl/hs_ack_delay.sv
module hs_ack_delay #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [DLY_W-1:0] dly,
  output logic             ack
);

  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W:0]   cnt_next;

  assign cnt_next = {1'b0, cnt_q} + {{DLY_W{1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      ack   <= 1'b0;
      cnt_q <= '0;
    end else if (req != ack) begin
      if (cnt_next >= {1'b0, dly}) begin
        ack   <= req;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_next[DLY_W-1:0];
      end
    end else begin
      cnt_q <= '0;
    end
  end

endmodule

// File: rtl/hs_seq_fsm.sv
module hs_seq_fsm
  import hs_cmd_seq_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           op_valid,
  input  logic [1:0]     op_kind,
  input  logic [NCH-1:0] ack,
  output logic [NCH-1:0] req,
  output logic           op_ready,
  output logic           op_done
);

  seq_state_e state_q;
  logic       acks_low;

  assign acks_low = ~|ack;
  assign op_ready = (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      req     <= '0;
      op_done <= 1'b0;
    end else begin
      op_done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (op_valid && acks_low) begin
            if (kind_is_test(op_kind)) begin
              req[CH_CMP] <= 1'b1;
              state_q     <= ST_CMP_UP;
            end else if (kind_is_reload(op_kind)) begin
              req[CH_LD]  <= 1'b1;
              state_q     <= ST_LD_UP;
            end else begin
              req[CH_SEL] <= 1'b1;
              state_q     <= ST_SEL_UP;
            end
          end
        end
        ST_SEL_UP: begin
          if (ack[CH_SEL]) begin
            req[CH_SEL] <= 1'b0;
            state_q     <= ST_SEL_DN;
          end
        end
        ST_SEL_DN: begin
          if (acks_low) begin
            req[CH_LD] <= 1'b1;
            state_q    <= ST_LD_UP;
          end
        end
        ST_LD_UP: begin
          if (ack[CH_LD]) begin
            req[CH_LD] <= 1'b0;
            state_q    <= ST_LD_DN;
          end
        end
        ST_LD_DN: begin
          if (acks_low) begin
            op_done <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_CMP_UP: begin
          if (ack[CH_CMP]) begin
            req[CH_CMP] <= 1'b0;
            state_q     <= ST_CMP_DN;
          end
        end
        ST_CMP_DN: begin
          if (acks_low) begin
            op_done <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: begin
          req     <= '0;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/hs_datapath.sv
module hs_datapath #(
  parameter int NSRC   = 4,
  parameter int DATA_W = 8,
  localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NSRC*DATA_W-1:0] src_bus,
  input  logic [SEL_W-1:0]       sel_val,
  input  logic [BIT_W-1:0]       bit_idx,
  input  logic                   ref_val,
  input  logic                   sel_req,
  input  logic                   load_req,
  input  logic                   cmp_req,
  output logic [DATA_W-1:0]      reg_q,
  output logic                   cmp_flag
);

  logic [SEL_W-1:0]  mux_sel_q;
  logic              sel_d, load_d, cmp_d;
  logic [DATA_W-1:0] mux_out;

  always_comb begin
    mux_out = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (mux_sel_q == SEL_W'(i)) mux_out = src_bus[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_d     <= 1'b0;
      load_d    <= 1'b0;
      cmp_d     <= 1'b0;
      mux_sel_q <= '0;
      reg_q     <= '0;
      cmp_flag  <= 1'b0;
    end else begin
      sel_d  <= sel_req;
      load_d <= load_req;
      cmp_d  <= cmp_req;
      if (sel_req && !sel_d)   mux_sel_q <= sel_val;
      if (load_req && !load_d) reg_q     <= mux_out;
      if (cmp_req && !cmp_d)   cmp_flag  <= (reg_q[bit_idx] == ref_val);
    end
  end

endmodule

// File: rtl/hs_cmd_seq.sv
module hs_cmd_seq
  import hs_cmd_seq_pkg::*;
#(
  parameter int NSRC   = 4,
  parameter int DATA_W = 8,
  parameter int DLY_W  = 4,
  localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   op_valid,
  output logic                   op_ready,
  input  logic [1:0]             op_kind,
  input  logic [SEL_W-1:0]       op_src,
  input  logic [BIT_W-1:0]       op_bit,
  input  logic                   op_ref,
  input  logic [DLY_W-1:0]       bund_dly,
  input  logic [NSRC*DATA_W-1:0] src_bus,
  output logic                   sel_req,
  output logic                   sel_ack,
  output logic                   load_req,
  output logic                   load_ack,
  output logic                   cmp_req,
  output logic                   cmp_ack,
  output logic [DATA_W-1:0]      reg_q,
  output logic                   branch_taken,
  output logic                   op_done
);

  logic [NCH-1:0]   req_v, ack_v;
  logic [SEL_W-1:0] src_q;
  logic [BIT_W-1:0] bit_q;
  logic             ref_q;
  logic [DLY_W-1:0] dly_q, dly_eff;
  logic             take;

  assign take    = op_valid && op_ready;
  assign dly_eff = (dly_q == '0) ? DLY_W'(1) : dly_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0;
      bit_q <= '0;
      ref_q <= 1'b0;
      dly_q <= DLY_W'(1);
    end else if (take) begin
      src_q <= op_src;
      bit_q <= op_bit;
      ref_q <= op_ref;
      dly_q <= bund_dly;
    end
  end

  hs_seq_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_kind  (op_kind),
    .ack      (ack_v),
    .req      (req_v),
    .op_ready (op_ready),
    .op_done  (op_done)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ack
    hs_ack_delay #(.DLY_W(DLY_W)) u_dly (
      .clk (clk),
      .rst (rst),
      .req (req_v[c]),
      .dly (dly_eff),
      .ack (ack_v[c])
    );
  end

  hs_datapath #(.NSRC(NSRC), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .src_bus  (src_bus),
    .sel_val  (src_q),
    .bit_idx  (bit_q),
    .ref_val  (ref_q),
    .sel_req  (req_v[CH_SEL]),
    .load_req (req_v[CH_LD]),
    .cmp_req  (req_v[CH_CMP]),
    .reg_q    (reg_q),
    .cmp_flag (branch_taken)
  );

  assign sel_req  = req_v[CH_SEL];
  assign load_req = req_v[CH_LD];
  assign cmp_req  = req_v[CH_CMP];
  assign sel_ack  = ack_v[CH_SEL];
  assign load_ack = ack_v[CH_LD];
  assign cmp_ack  = ack_v[CH_CMP];

endmodule

// File: rtl/hs_cmd_seq_chk.sv
module hs_cmd_seq_chk (
  input logic clk,
  input logic rst,
  input logic op_ready,
  input logic op_done,
  input logic sel_req,
  input logic sel_ack,
  input logic load_req,
  input logic load_ack,
  input logic cmp_req,
  input logic cmp_ack
);

  logic [2:0] reqs, acks;
  assign reqs = {cmp_req, load_req, sel_req};
  assign acks = {cmp_ack, load_ack, sel_ack};

  a_r4_one_request: assert property (@(posedge clk) disable iff (rst)
    $onehot0(reqs));

  a_r4_no_raise_under_ack: assert property (@(posedge clk) disable iff (rst)
    ($rose(sel_req) || $rose(load_req) || $rose(cmp_req)) |-> (acks == 3'b000));

  a_r3_ack_up_needs_req: assert property (@(posedge clk) disable iff (rst)
    ($rose(sel_ack) |-> sel_req) and ($rose(load_ack) |-> load_req)
    and ($rose(cmp_ack) |-> cmp_req));

  a_r3_ack_down_needs_req_low: assert property (@(posedge clk) disable iff (rst)
    ($fell(sel_ack) |-> !sel_req) and ($fell(load_ack) |-> !load_req)
    and ($fell(cmp_ack) |-> !cmp_req));

  a_r5_select_before_load: assert property (@(posedge clk) disable iff (rst)
    $rose(load_req) |-> (!sel_req && !sel_ack));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    op_ready |-> (reqs == 3'b000));

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    op_done |=> !op_done);

  a_r9_done_acks_low: assert property (@(posedge clk) disable iff (rst)
    op_done |-> (acks == 3'b000 && reqs == 3'b000));

endmodule

bind hs_cmd_seq hs_cmd_seq_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_ready (op_ready),
  .op_done  (op_done),
  .sel_req  (sel_req),
  .sel_ack  (sel_ack),
  .load_req (load_req),
  .load_ack (load_ack),
  .cmp_req  (cmp_req),
  .cmp_ack  (cmp_ack)
);

// File: tb/hs_cmd_seq_tb_top.sv
module hs_cmd_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [1:0]  op_kind = '0;
  logic [1:0]  op_src = '0;
  logic [2:0]  op_bit = '0;
  logic        op_ref = 1'b0;
  logic [3:0]  bund_dly = '0;
  logic [31:0] src_bus = {8'h01, 8'h80, 8'h3C, 8'hA5};
  logic        sel_req, sel_ack, load_req, load_ack, cmp_req, cmp_ack;
  logic [7:0]  reg_q;
  logic        branch_taken, op_done;

  int n_chk = 0;
  int n_err = 0;
  int cyc_total = 0;

  always #10 clk = ~clk;

  hs_cmd_seq dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op_kind(op_kind), .op_src(op_src), .op_bit(op_bit), .op_ref(op_ref),
    .bund_dly(bund_dly), .src_bus(src_bus),
    .sel_req(sel_req), .sel_ack(sel_ack), .load_req(load_req),
    .load_ack(load_ack), .cmp_req(cmp_req), .cmp_ack(cmp_ack),
    .reg_q(reg_q), .branch_taken(branch_taken), .op_done(op_done)
  );

  // Fields: kind[28:27] src[26:25] bit[24:22] ref[21] dly[20:17]
  //         exp_reg[16:9] exp_branch[8] exp_cycles[7:0]
  localparam int NVEC = 8;
  localparam logic [28:0] VEC [NVEC] = '{
    {2'b00, 2'd1, 3'd0, 1'b0, 4'd2, 8'h3C, 1'b0, 8'd12},
    {2'b10, 2'd0, 3'd2, 1'b1, 4'd1, 8'h3C, 1'b1, 8'd4},
    {2'b10, 2'd0, 3'd7, 1'b1, 4'd3, 8'h3C, 1'b0, 8'd8},
    {2'b00, 2'd2, 3'd0, 1'b0, 4'd0, 8'h80, 1'b0, 8'd8},
    {2'b11, 2'd0, 3'd7, 1'b1, 4'd1, 8'h80, 1'b1, 8'd4},
    {2'b00, 2'd0, 3'd0, 1'b0, 4'd4, 8'hA5, 1'b1, 8'd20},
    {2'b10, 2'd3, 3'd0, 1'b0, 4'd2, 8'hA5, 1'b0, 8'd6},
    {2'b01, 2'd3, 3'd0, 1'b0, 4'd1, 8'hA5, 1'b0, 8'd4}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 20000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc_total);
      finish_run();
    end
  end

  task automatic offer(input logic [1:0] k, input logic [1:0] s, input logic [2:0] b,
                       input logic r, input logic [3:0] d);
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    op_kind = k; op_src = s; op_bit = b; op_ref = r; bund_dly = d;
    op_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic run_op(input logic [1:0] k, input logic [1:0] s, input logic [2:0] b,
                        input logic r, input logic [3:0] d, output int cyc);
    offer(k, s, b, r, d);
    cyc = 0;
    while (!op_done && cyc < 200) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
  endtask

  function automatic logic probe(input int i);
    case (i)
      0: return sel_req;
      1: return sel_ack;
      2: return load_req;
      3: return load_ack;
      4: return cmp_req;
      default: return cmp_ack;
    endcase
  endfunction

  task automatic count_until(input int i, input logic lvl, output int k);
    k = 0;
    while (probe(i) !== lvl && k < 100) begin
      @(negedge clk);
      k++;
    end
  endtask

  initial begin
    int cyc;
    int k;
    logic busy_seen;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 reqs/acks in reset", {sel_req, sel_ack, load_req, load_ack, cmp_req, cmp_ack}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 op_ready after reset", op_ready, 1);
    check("R1 op_done after reset", op_done, 0);
    check("R1 reg_q after reset", reg_q, 0);
    check("R1 branch_taken after reset", branch_taken, 0);

    // Table walk: R5 R6 R7 R8 R9
    for (int v = 0; v < NVEC; v++) begin
      run_op(VEC[v][28:27], VEC[v][26:25], VEC[v][24:22], VEC[v][21], VEC[v][20:17], cyc);
      check($sformatf("R5/R7/R8 cycles to done, row %0d", v), cyc, VEC[v][7:0]);
      check($sformatf("R6/R7 reg_q, row %0d", v), reg_q, VEC[v][16:9]);
      check($sformatf("R8/R9 branch_taken, row %0d", v), branch_taken, VEC[v][8]);
      check($sformatf("R9 acks low at done, row %0d", v), {sel_ack, load_ack, cmp_ack}, 0);
      @(negedge clk);
      check($sformatf("R9 done one cycle, row %0d", v), op_done, 0);
    end

    // R7: reload takes the new value of the selected source, op_src ignored
    src_bus[7:0] = 8'h5A;
    run_op(2'b01, 2'd2, 3'd0, 1'b0, 4'd2, cyc);
    check("R7 reload uses last selection", reg_q, 8'h5A);
    check("R7 reload cycles", cyc, 6);

    // R3: acknowledge delay on rise and fall, N=3
    offer(2'b00, 2'd3, 3'd0, 1'b0, 4'd3);
    check("R3 select request up after accept", sel_req, 1);
    count_until(1, 1'b1, k);
    check("R3 ack rise delay", k, 3);
    count_until(0, 1'b0, k);
    check("R4 request drops one cycle after ack", k, 1);
    count_until(1, 1'b0, k);
    check("R3 ack fall delay", k, 3);
    count_until(2, 1'b1, k);
    check("R5 load request one cycle after select ack low", k, 1);
    while (!op_done) @(negedge clk);
    check("R6 assign from source 3", reg_q, 8'h01);

    // R2: op_valid while busy is ignored
    offer(2'b00, 2'd1, 3'd0, 1'b0, 4'd2);
    busy_seen = 1'b0;
    op_kind = 2'b00; op_src = 2'd2; op_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      if (!op_ready) busy_seen = 1'b1;
      @(negedge clk);
    end
    op_valid = 1'b0;
    check("R2 op_ready low while busy", busy_seen, 1);
    while (!op_done) @(negedge clk);
    check("R2 first op result kept", reg_q, 8'h3C);
    k = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (op_done || sel_req || load_req || cmp_req) k++;
    end
    check("R2 busy offer not executed later", k, 0);
    check("R2 reg_q unchanged after ignored offer", reg_q, 8'h3C);

    // R1: reset in the middle of an operation
    offer(2'b00, 2'd0, 3'd0, 1'b0, 4'd4);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 mid-op reset clears handshakes",
          {sel_req, sel_ack, load_req, load_ack, cmp_req, cmp_ack}, 0);
    check("R1 mid-op reset ready", op_ready, 1);
    check("R1 mid-op reset reg_q", reg_q, 0);
    rst = 1'b0;
    @(negedge clk);

    // R8: test after reset reads the cleared register
    run_op(2'b10, 2'd0, 3'd5, 1'b0, 4'd1, cyc);
    check("R8 bit 5 of zero equals 0", branch_taken, 1);
    check("R8 test cycles", cyc, 4);

    finish_run();
  end

endmodule